// File: doc/BRIEF.md
# Epoch-ordered write-back cache controller

This block is a small fully-associative write-back cache that sits between a CPU store path and a persistent memory port. Every line remembers whether its data targets persistent or volatile memory and which epoch last wrote it. Software closes an epoch with a one-cycle barrier pulse, and the controller guarantees that dirty persistent lines reach memory in epoch order, while lines of one epoch may leave in any order among themselves.

Victims are taken only from the oldest epoch still resident or in flight, so the replacement logic itself enforces the ordering. When a store cannot be placed, the CPU side is held off and the controller drains lines until room appears. The memory side presents one write-back at a time with a valid/ready handshake and receives a separate acknowledge per accepted write-back. Up to two write-backs of one epoch may be outstanding.

Top module: `epc_cache`

## Requirements
- R1: After reset no write-back is presented (wb_valid low) and the CPU side is ready while idle; a write-back is only ever started while a CPU store is being held off.
- R2: The epoch counter is 8 bits, starts at 0, rises by exactly one per cycle with cpu_barrier high and wraps modulo 256; an accepted store is tagged with the counter value before any barrier in the same cycle, and that tag appears on wb_epoch. Software keeps fewer than 128 epochs live.
- R3: A store that hits a line which is clean, volatile, or already tagged with the current epoch is accepted in the same cycle and causes no write-back.
- R4: A store that hits a dirty persistent line of an older epoch is held off until that line has been handed to the write-back path; the line is then rewritten and retagged with the current epoch.
- R5: A store that misses is accepted in the same cycle when an invalid or clean line exists.
- R6: A store that misses with every line dirty is held off (cpu_ready low) until a write-back frees a line.
- R7: Persistent write-backs (wb_pers = 1) are presented in non-decreasing epoch order; all come from the oldest epoch among dirty and outstanding persistent data.
- R8: A persistent write-back is presented only while every outstanding write-back is persistent and of the same epoch; a volatile write-back only when nothing is outstanding.
- R9: At most two write-backs are outstanding, counting the one presented and those accepted but not yet acknowledged.
- R10: Once wb_valid is high it stays high with wb_addr and wb_data unchanged until wb_ready is seen.
- R11: On a miss with no free line, a dirty volatile line is chosen before any persistent one and is presented with wb_pers = 0.
- R12: The data of a write-back equals the last value stored to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_valid | input | 1 | CPU store request |
| cpu_ready | output | 1 | Store accepted at this edge when high with cpu_valid |
| cpu_addr | input | AW | Store address (one word per line) |
| cpu_data | input | DW | Store data |
| cpu_pers | input | 1 | 1: address is persistent, 0: volatile |
| cpu_barrier | input | 1 | Closes the current epoch |
| wb_valid | output | 1 | Write-back presented |
| wb_ready | input | 1 | Memory takes the write-back at this edge |
| wb_addr | output | AW | Write-back address |
| wb_data | output | DW | Write-back data |
| wb_pers | output | 1 | Write-back targets persistent memory |
| wb_epoch | output | 8 | Epoch tag of the write-back |
| wb_ack | input | 1 | One accepted write-back has completed |

## Verification
cpu_ready is combinational on the current request and line state, so a hold-off is visible in the same cycle the store is presented; the bench drives a store on the falling edge and reads cpu_ready shortly after, recording the store in its shadow model only when it will be taken at the next rising edge. A write-back is decided in a held-off cycle and wb_valid rises at the following rising edge, so the bench detects each new write-back at the next falling edge and compares it to the shadow copy as of that moment, which no store can have changed in between. Handshake and acknowledge outcomes are predicted on the falling edge before the edge that applies them, and the outstanding count and hold stability are compared on every clock.

// File: rtl/epc_pkg.sv
// Shared types for the epoch-ordered cache.
// Assumes an 8-bit epoch tag compared by serial-number distance.
package epc_pkg;
    localparam int EPOCH_W = 8;
    typedef logic [EPOCH_W-1:0] epoch_t;

    typedef struct packed {
        logic   valid;
        logic   dirty;
        logic   pers;
        epoch_t epoch;
    } meta_t;

    // distance of an epoch behind the current one (modulo 2^EPOCH_W)
    function automatic epoch_t epoch_age(input epoch_t cur, input epoch_t e);
        return cur - e;
    endfunction
endpackage

// File: rtl/epc_lookup.sv
// Address match and free-line search over all lines.
// Assumes tags are unique among valid lines; lowest index wins a tie.
module epc_lookup
    import epc_pkg::*;
#(
    parameter int LINES = 8,
    parameter int AW    = 8,
    localparam int IW   = $clog2(LINES)
) (
    input  meta_t           meta [LINES],
    input  logic [AW-1:0]   tags [LINES],
    input  logic [AW-1:0]   addr,
    output logic            hit,
    output logic [IW-1:0]   hit_idx,
    output logic            free_found,
    output logic [IW-1:0]   free_idx
);
    // scan from the top so the lowest matching index is kept
    always_comb begin
        hit        = 1'b0;
        hit_idx    = '0;
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (meta[i].valid && tags[i] == addr) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
            if (!meta[i].valid || !meta[i].dirty) begin
                free_found = 1'b1;
                free_idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/epc_select.sv
// Finds the oldest live persistent epoch and the victim candidates.
// Assumes fewer than 128 live epochs so the largest age is the oldest.
module epc_select
    import epc_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IW   = $clog2(LINES)
) (
    input  meta_t           meta [LINES],
    input  epoch_t          cur,
    input  logic            out_active,
    input  epoch_t          out_epoch,
    output epoch_t          oldest,
    output logic            per_found,
    output logic [IW-1:0]   per_idx,
    output logic            vol_found,
    output logic [IW-1:0]   vol_idx
);
    epoch_t max_age;

    // oldest epoch among dirty persistent lines and outstanding write-backs
    always_comb begin
        max_age = '0;
        for (int i = 0; i < LINES; i++) begin
            if (meta[i].valid && meta[i].dirty && meta[i].pers &&
                epoch_age(cur, meta[i].epoch) > max_age)
                max_age = epoch_age(cur, meta[i].epoch);
        end
        if (out_active && epoch_age(cur, out_epoch) > max_age)
            max_age = epoch_age(cur, out_epoch);
        oldest = cur - max_age;
    end

    // lowest-index eligible persistent line and dirty volatile line
    always_comb begin
        per_found = 1'b0;
        per_idx   = '0;
        vol_found = 1'b0;
        vol_idx   = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (meta[i].valid && meta[i].dirty && meta[i].pers && meta[i].epoch == oldest) begin
                per_found = 1'b1;
                per_idx   = IW'(i);
            end
            if (meta[i].valid && meta[i].dirty && !meta[i].pers) begin
                vol_found = 1'b1;
                vol_idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/epc_wb_track.sv
// Counts write-backs presented or awaiting acknowledge and their epoch.
// Assumes wb_ack only answers an accepted write-back, in order.
module epc_wb_track
    import epc_pkg::*;
#(
    parameter int MAX_OUT = 2,
    parameter int CW      = $clog2(MAX_OUT + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wb_valid,
    input  logic          wb_ready,
    input  logic          wb_ack,
    input  logic          wb_pers,
    input  epoch_t        wb_epoch,
    output logic [CW-1:0] out_cnt,
    output logic          out_pers,
    output epoch_t        out_epoch
);
    logic [CW-1:0] inflight;
    logic          acc_pers;
    epoch_t        acc_epoch;
    logic          take;

    assign take = wb_valid && wb_ready;

    // accepted-but-unacknowledged count and the tag of that group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight  <= '0;
            acc_pers  <= 1'b0;
            acc_epoch <= '0;
        end else begin
            if (take && !wb_ack)      inflight <= inflight + 1'b1;
            else if (!take && wb_ack) inflight <= inflight - 1'b1;
            if (take) begin
                acc_pers  <= wb_pers;
                acc_epoch <= wb_epoch;
            end
        end
    end

    // outstanding view seen by the victim selection
    assign out_cnt   = inflight + CW'(wb_valid);
    assign out_pers  = wb_valid ? wb_pers  : acc_pers;
    assign out_epoch = wb_valid ? wb_epoch : acc_epoch;

    AST_OUT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= CW'(MAX_OUT)); // R9
    AST_ACK_OWED: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |-> inflight != '0); // R8
    AST_SAME_EPOCH: assert property (@(posedge clk) disable iff (!rst_n)
        (take && inflight != '0) |-> (wb_pers && acc_pers && wb_epoch == acc_epoch)); // R8
endmodule

// File: rtl/epc_cache.sv
// Fully-associative write-back cache that drains persistent lines in epoch order.
// Assumes one word per line, no read path, and fewer than 128 live epochs.
module epc_cache
    import epc_pkg::*;
#(
    parameter int LINES   = 8,
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int MAX_OUT = 2,
    localparam int IW     = $clog2(LINES),
    localparam int CW     = $clog2(MAX_OUT + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_valid,
    output logic               cpu_ready,
    input  logic [AW-1:0]      cpu_addr,
    input  logic [DW-1:0]      cpu_data,
    input  logic               cpu_pers,
    input  logic               cpu_barrier,
    output logic               wb_valid,
    input  logic               wb_ready,
    output logic [AW-1:0]      wb_addr,
    output logic [DW-1:0]      wb_data,
    output logic               wb_pers,
    output logic [EPOCH_W-1:0] wb_epoch,
    input  logic               wb_ack
);
    meta_t         meta [LINES];
    logic [AW-1:0] tags [LINES];
    logic [DW-1:0] dat  [LINES];
    epoch_t        cur;

    logic          hit, free_found, per_found, vol_found;
    logic [IW-1:0] hit_idx, free_idx, per_idx, vol_idx, issue_idx, widx;
    epoch_t        oldest, out_epoch;
    logic [CW-1:0] out_cnt;
    logic          out_pers;
    logic          hit_old, room, accept, stall, want_vol, can_pers, issue;

    epc_lookup #(.LINES(LINES), .AW(AW)) u_lookup (
        .meta(meta), .tags(tags), .addr(cpu_addr),
        .hit(hit), .hit_idx(hit_idx), .free_found(free_found), .free_idx(free_idx)
    );

    epc_select #(.LINES(LINES)) u_select (
        .meta(meta), .cur(cur),
        .out_active(out_cnt != '0 && out_pers), .out_epoch(out_epoch),
        .oldest(oldest), .per_found(per_found), .per_idx(per_idx),
        .vol_found(vol_found), .vol_idx(vol_idx)
    );

    epc_wb_track #(.MAX_OUT(MAX_OUT), .CW(CW)) u_track (
        .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_ready(wb_ready),
        .wb_ack(wb_ack), .wb_pers(wb_pers), .wb_epoch(wb_epoch),
        .out_cnt(out_cnt), .out_pers(out_pers), .out_epoch(out_epoch)
    );

    // placement decision and drain choice for the presented store
    always_comb begin
        hit_old   = hit && meta[hit_idx].dirty && meta[hit_idx].pers && meta[hit_idx].epoch != cur;
        room      = hit ? !hit_old : free_found;
        cpu_ready = !cpu_valid || room;
        accept    = cpu_valid && room;
        stall     = cpu_valid && !room;
        widx      = hit ? hit_idx : free_idx;
        want_vol  = !hit && vol_found;
        can_pers  = !wb_valid && (out_cnt == '0 ||
                    (out_pers && out_epoch == oldest && out_cnt < CW'(MAX_OUT)));
        issue     = stall && (want_vol ? (out_cnt == '0) : (per_found && can_pers));
        issue_idx = want_vol ? vol_idx : per_idx;
    end

    // epoch counter advanced by the barrier pulse
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= '0;
        else if (cpu_barrier) cur <= cur + 1'b1;
    end

    // line state: fill or rewrite on accept, clean on hand-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) meta[i] <= '0;
        end else if (accept) begin
            meta[widx] <= '{valid: 1'b1, dirty: 1'b1, pers: cpu_pers, epoch: cur};
        end else if (issue) begin
            meta[issue_idx].dirty <= 1'b0;
        end
    end

    // line payload storage
    always_ff @(posedge clk) begin
        if (accept) begin
            tags[widx] <= cpu_addr;
            dat[widx]  <= cpu_data;
        end
    end

    // write-back register, held until the memory side takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_addr  <= '0;
            wb_data  <= '0;
            wb_pers  <= 1'b0;
            wb_epoch <= '0;
        end else if (issue) begin
            wb_valid <= 1'b1;
            wb_addr  <= tags[issue_idx];
            wb_data  <= dat[issue_idx];
            wb_pers  <= meta[issue_idx].pers;
            wb_epoch <= meta[issue_idx].epoch;
        end else if (wb_valid && wb_ready) begin
            wb_valid <= 1'b0;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data))); // R10
    AST_ISSUE_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_valid) |-> $past(cpu_valid && !cpu_ready)); // R1
endmodule

// File: tb/epc_cache_tb.sv
`timescale 1ns/1ps
module epc_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0, cpu_pers = 1'b0, cpu_barrier = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_data = '0;
    logic        cpu_ready;
    logic        wb_valid, wb_pers;
    logic        wb_ready = 1'b0, wb_ack = 1'b0;
    logic [7:0]  wb_addr, wb_epoch;
    logic [31:0] wb_data;

    always #2.5 clk = ~clk;

    epc_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_pers(cpu_pers),
        .cpu_barrier(cpu_barrier), .wb_valid(wb_valid), .wb_ready(wb_ready),
        .wb_addr(wb_addr), .wb_data(wb_data), .wb_pers(wb_pers),
        .wb_epoch(wb_epoch), .wb_ack(wb_ack)
    );

    int checks = 0, errors = 0, cyc = 0;
    logic [31:0] sh_data [0:255];
    int          sh_ep   [0:255];
    bit          sh_pers [0:255];
    int bench_ep = 0;
    int q_rdy[$]; int q_ep[$]; bit q_pers[$];
    int ev_addr[$]; int ev_ep[$]; bit ev_pers[$];
    int last_pers_ep = -1, issue_ep = 0;
    bit prev_valid = 0, prev_hold = 0;
    logic [7:0] prev_addr = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // memory model and per-clock comparison against the shadow model
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            wb_ready = (cyc % 4) != 1;
            wb_ack   = (q_rdy.size() > 0) && (cyc >= q_rdy[0]);
            #1;
            if (prev_hold)
                check(wb_valid && wb_addr == prev_addr, "R10", int'(wb_addr), int'(prev_addr));
            if (wb_valid && !prev_valid) begin
                issue_ep = sh_ep[wb_addr];
                ev_addr.push_back(int'(wb_addr));
                ev_ep.push_back(issue_ep);
                ev_pers.push_back(wb_pers);
                check(wb_data == sh_data[wb_addr], "R12", int'(wb_data), int'(sh_data[wb_addr]));
                check(wb_pers == sh_pers[wb_addr], "R11", int'(wb_pers), int'(sh_pers[wb_addr]));
                check(wb_epoch == 8'(issue_ep), "R2", int'(wb_epoch), issue_ep % 256);
                if (wb_pers) begin
                    check(issue_ep >= last_pers_ep, "R7", issue_ep, last_pers_ep);
                    last_pers_ep = issue_ep;
                    foreach (q_ep[i])
                        check(q_pers[i] && q_ep[i] == issue_ep, "R8", q_ep[i], issue_ep);
                end else begin
                    check(q_rdy.size() == 0, "R8", q_rdy.size(), 0);
                end
            end
            check(q_rdy.size() + int'(wb_valid) <= 2, "R9", q_rdy.size() + int'(wb_valid), 2);
            if (wb_ack) begin
                void'(q_rdy.pop_front()); void'(q_ep.pop_front()); void'(q_pers.pop_front());
            end
            if (wb_valid && wb_ready) begin
                q_rdy.push_back(cyc + 1 + (cyc % 3));
                q_ep.push_back(issue_ep);
                q_pers.push_back(wb_pers);
            end
            prev_valid = wb_valid;
            prev_hold  = wb_valid && !wb_ready;
            prev_addr  = wb_addr;
        end
    end

    task automatic cpu_wr(input int a, input int d, input bit p, output bit stalled);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = 8'(a); cpu_data = 32'(d); cpu_pers = p;
        stalled = 1'b0;
        #2;
        while (!cpu_ready) begin
            stalled = 1'b1;
            @(negedge clk); #2;
        end
        sh_data[a] = 32'(d); sh_ep[a] = bench_ep; sh_pers[a] = p;
        @(posedge clk); #1;
        cpu_valid = 1'b0;
    endtask

    task automatic barrier();
        @(negedge clk); cpu_barrier = 1'b1;
        @(posedge clk); #1; cpu_barrier = 1'b0;
        bench_ep++;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit s;
        int n0;
        for (int i = 0; i < 256; i++) begin sh_data[i] = '0; sh_ep[i] = 0; sh_pers[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check(wb_valid == 1'b0, "R1", int'(wb_valid), 0);
        check(cpu_ready == 1'b1, "R1", int'(cpu_ready), 1);

        // R5 miss into an empty cache
        cpu_wr(1, 100, 1, s);
        check(!s, "R5", int'(s), 0);
        // R3 hits on same-epoch and volatile lines
        cpu_wr(1, 101, 1, s);
        check(!s, "R3", int'(s), 0);
        cpu_wr(2, 200, 0, s);
        cpu_wr(2, 201, 1, s);
        check(!s, "R3", int'(s), 0);
        check(ev_addr.size() == 0, "R3", ev_addr.size(), 0);

        // R4 hit on an older-epoch dirty persistent line
        barrier();
        cpu_wr(1, 102, 1, s);
        check(s, "R4", int'(s), 1);
        check(ev_addr.size() == 1 && ev_addr[0] == 1, "R4", ev_addr.size() > 0 ? ev_addr[0] : -1, 1);

        // R6 / R7 full cache, misses drain oldest epoch first
        for (int k = 0; k < 6; k++) cpu_wr(10 + k, 1000 + k, 1, s);
        check(!s, "R5", int'(s), 0);
        barrier();
        n0 = ev_addr.size();
        cpu_wr(20, 2000, 1, s);
        check(s, "R6", int'(s), 1);
        check(ev_addr.size() > n0 && ev_ep[n0] == 0, "R7", ev_addr.size() > n0 ? ev_ep[n0] : -1, 0);
        for (int k = 1; k < 4; k++) cpu_wr(20 + k, 2000 + k, 1, s);

        // R11 dirty volatile line chosen before persistent ones
        barrier();
        cpu_wr(40, 4000, 0, s);
        cpu_wr(41, 4001, 0, s);
        n0 = ev_addr.size();
        cpu_wr(50, 5000, 1, s);
        check(s, "R6", int'(s), 1);
        check(ev_addr.size() > n0 && ev_pers[n0] == 1'b0, "R11",
              ev_addr.size() > n0 ? int'(ev_pers[n0]) : -1, 0);

        // R2 epoch wrap: refill with fresh epochs across the modulo boundary
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < 8; k++) cpu_wr(60 + 8 * r + k, 6000 + 100 * r + k, 1, s);
            for (int b = 0; b < 120; b++) barrier();
        end
        for (int k = 0; k < 8; k++) cpu_wr(100 + k, 9000 + k, 1, s);
        check(bench_ep > 256, "R2", bench_ep, 257);
        check(last_pers_ep >= 360, "R7", last_pers_ep, 360);

        repeat (30) @(negedge clk);
        check(q_rdy.size() == 0 && !wb_valid, "R9", q_rdy.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule